// File: doc/BRIEF.md
# General-Purpose I/O Bank with Wake-on-Change

This block controls a bank of 27 general-purpose pins. Bits 0 to 23 are push-pull and bits 24 to 26 are open-drain: an open-drain pin can only sink current and floats when its output value is 1. Software sets the output value and the direction of each bit separately through a small register port that is written synchronously and read combinationally. One group of four bits, bits 16 to 19, also has a pull resistor that software can enable and set to pull up or pull down while the bit is an input. Each pin also has an override input that takes the pin over from the registers and drives it from a side signal.

Every pad input passes through a two-flop synchronizer before it can be read or compared. While the standby input is high, the block watches its inputs. When standby goes high it stores the synchronized input values as a reference. A one-cycle wake pulse follows whenever an input-mode bit in an enabled group differs from that reference. Wake is enabled per group of four bits, not per bit, so a system can make some ports wake sources and keep others quiet. After each pulse the reference takes the new value, so each change gives exactly one pulse.

Top module: `gpio_wake_bank`

## Requirements
- R1: After reset, all registers read 0: every bit is an input, the output data is 0, the pulls are off and wake is disabled for all groups. All of pad_oe, pull_up, pull_dn and wake are 0.
- R2: A level on pad_in shows at register address 5 (synchronized input) after the second rising clock edge, and not after the first.
- R3: For push-pull bits 0 to 23 with no override, pad_oe equals the direction bit (1 means output) and pad_out equals the data bit.
- R4: For open-drain bits 24 to 26, pad_out is always 0. With no override, pad_oe is 1 only when the bit is an output and its data bit is 0.
- R5: Only bits 16 to 19 have pulls. For bit 16+k, pull enable bit k at address 2 and pull select bit k at address 3 (1 means up, 0 means down) give pull_up or pull_dn. The pull is active only while that bit is an input and not overridden. pull_up and pull_dn are never both high.
- R6: When alt_en[i] is 1, pin i acts as an output of value alt_out[i]. A push-pull pin then has pad_oe 1 and pad_out alt_out[i]. An open-drain pin then has pad_oe equal to not alt_out[i].
- R7: Wake enable bit g at address 4 covers bits 4g to 4g+3. Group 6 covers bits 24 to 26. While standby is high, a change of an input bit in an enabled group raises wake for exactly one cycle, after the third rising edge that follows the pad change.
- R8: Bits in output mode, overridden bits and bits in disabled groups never raise wake.
- R9: The reference is captured at the first rising edge at which standby is high. With standby low, wake stays 0. After a pulse the reference follows the new level, so one change gives one pulse and the change back gives another.
- R10: The register map is: 0 output data (27 bits), 1 direction (27 bits), 2 pull enable (4 bits), 3 pull select (4 bits), 4 wake enable (7 bits), 5 synchronized input (read only). Bits above a register's width, and addresses 6 and 7, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 27 | Write data |
| reg_rdata | output | 27 | Read data for reg_addr (combinational) |
| pad_in | input | 27 | Pad input levels (asynchronous) |
| alt_en | input | 27 | Override enable for each pin |
| alt_out | input | 27 | Override output value for each pin |
| pad_out | output | 27 | Pad output value |
| pad_oe | output | 27 | Pad output enable |
| pull_up | output | 27 | Pull-up enable for each pin |
| pull_dn | output | 27 | Pull-down enable for each pin |
| standby | input | 1 | Standby state active |
| wake | output | 1 | One-cycle wake pulse |

## Verification
Entering standby and a pin change can reach the block on the same clock edge. The bench changes a pad level and raises standby half a cycle after the first synchronizer stage takes it, so the second stage updates on the same edge that captures the reference. The reference must then hold the old level, and a wake pulse must follow one cycle later. The opposite order is also checked: with the pads stable before standby rises, no pulse may appear.

// File: rtl/gpio_wake_bank.sv
module gpio_wake_bank #(
  parameter int PP_BITS  = 24,
  parameter int OD_BITS  = 3,
  parameter int GRP_W    = 4,
  parameter int PULL_GRP = 4,
  parameter int AW       = 3,
  localparam int N       = PP_BITS + OD_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [N-1:0] reg_wdata,
  output logic [N-1:0] reg_rdata,
  input  logic [N-1:0] pad_in,
  input  logic [N-1:0] alt_en,
  input  logic [N-1:0] alt_out,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe,
  output logic [N-1:0] pull_up,
  output logic [N-1:0] pull_dn,
  input  logic         standby,
  output logic         wake
);
  localparam int NGRP    = (N + GRP_W - 1) / GRP_W;
  localparam int PULL_LO = PULL_GRP * GRP_W;

  logic [N-1:0]     dout, dir;
  logic [GRP_W-1:0] pull_en, pull_sel;
  logic [NGRP-1:0]  wake_en;
  logic [N-1:0]     sync_a, sync_q, ref_q;
  logic [N-1:0]     grp_mask, sense;
  logic             armed, wake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout     <= '0;
      dir      <= '0;
      pull_en  <= '0;
      pull_sel <= '0;
      wake_en  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        3'd0: dout     <= reg_wdata;
        3'd1: dir      <= reg_wdata;
        3'd2: pull_en  <= reg_wdata[GRP_W-1:0];
        3'd3: pull_sel <= reg_wdata[GRP_W-1:0];
        3'd4: wake_en  <= reg_wdata[NGRP-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      3'd0: reg_rdata = dout;
      3'd1: reg_rdata = dir;
      3'd2: reg_rdata[GRP_W-1:0] = pull_en;
      3'd3: reg_rdata[GRP_W-1:0] = pull_sel;
      3'd4: reg_rdata[NGRP-1:0] = wake_en;
      3'd5: reg_rdata = sync_q;
      default: ;
    endcase
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic drive, val;
    assign drive       = alt_en[i] | dir[i];
    assign val         = alt_en[i] ? alt_out[i] : dout[i];
    assign grp_mask[i] = wake_en[i / GRP_W];
    assign sense[i]    = grp_mask[i] & ~drive;

    if (i < PP_BITS) begin : g_pp
      assign pad_oe[i]  = drive;
      assign pad_out[i] = val;
    end else begin : g_od
      assign pad_oe[i]  = drive & ~val;
      assign pad_out[i] = 1'b0;
    end

    if (i >= PULL_LO && i < PULL_LO + GRP_W) begin : g_pull
      assign pull_up[i] = ~drive & pull_en[i-PULL_LO] &  pull_sel[i-PULL_LO];
      assign pull_dn[i] = ~drive & pull_en[i-PULL_LO] & ~pull_sel[i-PULL_LO];
    end else begin : g_nopull
      assign pull_up[i] = 1'b0;
      assign pull_dn[i] = 1'b0;
    end
  end

  logic enter, fire;
  assign enter = standby & ~armed;
  assign fire  = standby & armed & (|((ref_q ^ sync_q) & sense));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_q <= '0;
      ref_q  <= '0;
      armed  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      sync_a <= pad_in;
      sync_q <= sync_a;
      armed  <= standby;
      wake_q <= fire;
      if (enter | fire) ref_q <= sync_q;
    end
  end

  assign wake = wake_q;
endmodule

// File: rtl/gpio_wake_bank_chk.sv
module gpio_wake_bank_chk #(
  parameter int N       = 27,
  parameter int NGRP    = 7,
  parameter int GRP_W   = 4,
  parameter int PULL_LO = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            standby,
  input logic            wake,
  input logic [N-1:0]    pad_in,
  input logic [N-1:0]    sync_q,
  input logic [N-1:0]    ref_q,
  input logic            armed,
  input logic [NGRP-1:0] wake_en,
  input logic [N-1:0]    pull_up,
  input logic [N-1:0]    pull_dn
);
  localparam logic [N-1:0] PMASK = N'((1 << GRP_W) - 1) << PULL_LO;

  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;

  a_r2_sync_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3) |-> (sync_q == $past(pad_in, 2)));

  a_r7_wake_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(standby));

  a_r8_wake_needs_group: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> $past(|wake_en));

  a_r9_ref_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> (ref_q == $past(sync_q)));

  a_r5_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    ((pull_up & pull_dn) == '0) && (((pull_up | pull_dn) & ~PMASK) == '0));
endmodule

bind gpio_wake_bank gpio_wake_bank_chk #(
  .N(N), .NGRP(NGRP), .GRP_W(GRP_W), .PULL_LO(PULL_LO)
) chk_i (
  .clk(clk), .rst_n(rst_n), .standby(standby), .wake(wake),
  .pad_in(pad_in), .sync_q(sync_q), .ref_q(ref_q), .armed(armed),
  .wake_en(wake_en), .pull_up(pull_up), .pull_dn(pull_dn)
);

// File: tb/gpio_wake_bank_tb_top.sv
module gpio_wake_bank_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 27;
  localparam int PP = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [2:0]   reg_addr = '0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic [N-1:0] pad_in = '0;
  logic [N-1:0] alt_en = '0;
  logic [N-1:0] alt_out = '0;
  logic [N-1:0] pad_out, pad_oe, pull_up, pull_dn;
  logic         standby = 1'b0;
  logic         wake;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_wake_bank dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .alt_en(alt_en), .alt_out(alt_out), .pad_out(pad_out), .pad_oe(pad_oe),
    .pull_up(pull_up), .pull_dn(pull_dn), .standby(standby), .wake(wake)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic logic [N-1:0] exp_oe(logic [N-1:0] d, logic [N-1:0] r,
                                          logic [N-1:0] ae, logic [N-1:0] ao);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) begin
      logic drv, val;
      drv = ae[i] | r[i];
      val = ae[i] ? ao[i] : d[i];
      v[i] = (i < PP) ? drv : (drv & !val);
    end
    return v;
  endfunction

  function automatic logic [N-1:0] exp_out(logic [N-1:0] d, logic [N-1:0] ae,
                                           logic [N-1:0] ao);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = (i < PP) ? (ae[i] ? ao[i] : d[i]) : 1'b0;
    return v;
  endfunction

  task automatic toggle_and_check(int b, bit expect_wake, string req);
    pad_in[b] = ~pad_in[b];
    @(negedge clk);
    @(negedge clk);
    check(req, {31'b0, wake}, 32'd0);
    @(negedge clk);
    check(req, {31'b0, wake}, {31'b0, expect_wake});
    @(negedge clk);
    check("R9 single pulse", {31'b0, wake}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      reg_addr = 3'(a);
      #1 check("R1 reg reset", 32'(reg_rdata), 32'd0);
    end
    check("R1 pad_oe", 32'(pad_oe), 32'd0);
    check("R1 pulls", 32'(pull_up | pull_dn), 32'd0);
    check("R1 wake", {31'b0, wake}, 32'd0);

    // R10 register widths and unused addresses
    for (int a = 0; a < 8; a++) begin
      logic [N-1:0] e;
      if (a == 5) continue;
      wr(3'(a), '1);
      reg_addr = 3'(a);
      e = (a < 2) ? '1 : (a < 4) ? 27'hF : (a == 4) ? 27'h7F : '0;
      #1 check("R10 readback", 32'(reg_rdata), 32'(e));
      wr(3'(a), '0);
    end

    // R2 synchronizer depth
    @(negedge clk);
    pad_in = 27'h5A5A5A5;
    reg_addr = 3'd5;
    @(negedge clk);
    check("R2 after one edge", 32'(reg_rdata), 32'd0);
    @(negedge clk);
    check("R2 after two edges", 32'(reg_rdata), 32'h5A5A5A5);
    pad_in = '0;
    repeat (2) @(negedge clk);

    // R3 R4 R6 drive sweep
    for (int k = 0; k < 16; k++) begin
      logic [N-1:0] d, r, ae, ao;
      d  = 27'(32'h9E3779B9 * (k + 1));
      r  = 27'(32'h7F4A7C15 ^ (k * 32'h01010101));
      ae = (k < 8) ? '0 : 27'(32'h2545F491 * k);
      ao = 27'(~(32'h1B873593 * k));
      if (k == 1) r = '1;
      if (k == 2) d = '0;
      wr(3'd0, d);
      wr(3'd1, r);
      alt_en = ae; alt_out = ao;
      #1;
      check(k < 8 ? "R3 pad_oe" : "R6 pad_oe", 32'(pad_oe[PP-1:0]), 32'(exp_oe(d, r, ae, ao) & 27'hFFFFFF));
      check(k < 8 ? "R3 pad_out" : "R6 pad_out", 32'(pad_out[PP-1:0]), 32'(exp_out(d, ae, ao) & 27'hFFFFFF));
      check(k < 8 ? "R4 od oe" : "R6 od oe", 32'(pad_oe[N-1:PP]), 32'(exp_oe(d, r, ae, ao) >> PP));
      check("R4 od out", 32'(pad_out[N-1:PP]), 32'd0);
    end
    alt_en = '0; alt_out = '0;
    wr(3'd0, '0);

    // R5 pull sweep
    for (int m = 0; m < 3; m++) begin
      logic [N-1:0] r;
      r = (m == 0) ? '0 : (m == 1) ? '1 : 27'h0A0000;
      wr(3'd1, r);
      for (int pe = 0; pe < 16; pe++) begin
        wr(3'd2, 27'(pe));
        for (int ps = 0; ps < 16; ps++) begin
          logic [3:0] inp;
          wr(3'd3, 27'(ps));
          inp = ~r[19:16];
          check("R5 pull_up", 32'(pull_up), 32'({4'(pe & ps) & inp, 16'h0}));
          check("R5 pull_dn", 32'(pull_dn), 32'({4'(pe & ~ps) & inp, 16'h0}));
        end
      end
    end
    wr(3'd1, 27'h0);
    wr(3'd2, 27'hF);
    wr(3'd3, 27'hF);
    alt_en = 27'h050000;
    #1 check("R5 override blocks pull", 32'(pull_up), 32'h000A0000);
    alt_en = '0;
    wr(3'd2, '0);

    // R7 R8 group sweep
    for (int g = 0; g < 7; g++) begin
      wr(3'd4, 27'(1 << g));
      @(negedge clk); standby = 1'b1;
      repeat (3) @(negedge clk);
      for (int b = 0; b < N; b++) begin
        toggle_and_check(b, (b / 4) == g, (b / 4) == g ? "R7 enabled group" : "R8 other group");
        toggle_and_check(b, (b / 4) == g, (b / 4) == g ? "R7 change back" : "R8 other group");
      end
      standby = 1'b0;
    end

    // R8 output mode and override
    wr(3'd4, 27'h7F);
    wr(3'd1, '1);
    @(negedge clk); standby = 1'b1;
    repeat (3) @(negedge clk);
    for (int b = 0; b < N; b++) toggle_and_check(b, 1'b0, "R8 output mode");
    wr(3'd1, '0);
    alt_en = '1;
    for (int b = 0; b < N; b++) toggle_and_check(b, 1'b0, "R8 override");
    alt_en = '0;
    standby = 1'b0;
    repeat (3) @(negedge clk);

    // R9 no wake outside standby
    for (int b = 0; b < N; b += 5) toggle_and_check(b, 1'b0, "R9 standby low");

    // R9 stable entry: no pulse
    pad_in = 27'h1234567;
    repeat (4) @(negedge clk);
    standby = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      check("R9 stable entry", {31'b0, wake}, 32'd0);
    end
    standby = 1'b0;
    repeat (2) @(negedge clk);

    // R9 entry coinciding with second sync stage update
    pad_in[3] = ~pad_in[3];
    @(negedge clk);
    standby = 1'b1;
    @(negedge clk);
    check("R9 coincident entry early", {31'b0, wake}, 32'd0);
    @(negedge clk);
    check("R9 coincident entry pulse", {31'b0, wake}, 32'd1);
    @(negedge clk);
    check("R9 coincident entry end", {31'b0, wake}, 32'd0);
    standby = 1'b0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule